// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block steers hazards for a five-stage in-order integer pipeline: fetch, decode, execute, memory and writeback. Each cycle it receives the register indices, write enables, load flags and store flags of the instructions held in the decode, execute, memory and writeback pipeline registers. From these it returns three things. The first is the operand-bypass selects for the execute stage and for the store-data input of the memory stage. The second is the hold and bubble controls that create a stall. The third is the kill controls that squash younger work when a control transfer resolves. All of these outputs are combinational from the current inputs.

A parameter picks one of two builds. The bypassing build has three bypass paths. The interlock build uses no bypass and holds a dependent instruction in decode until its producer has left the memory stage. Three free-running counters record stall cycles, bypass events and redirects, and each is readable at a port.

The datapath is assumed to behave as follows. Bubbles and unused source fields carry index 0 and clear write enables. The register file is write-through, so a decode read sees the value being written back in the same cycle. Control transfers resolve in execute. The block has no data stream of its own, so it has no valid/ready handshake; every pin is a plain level-sensitive control or status signal.

Top module: `hazard_ctrl`

## Requirements
- R1: In the bypassing build, an execute operand select is 1 (EX/MEM result) when its nonzero source index equals mem_rd with mem_we set. Otherwise it is 2 (MEM/WB result) when the index equals wb_rd with wb_we set. Otherwise it is 0 (register file). The younger EX/MEM match wins when both match.
- R2: A source index of 0 never produces a nonzero select, a stall or a bypass count.
- R3: When the instruction in execute is a store (ex_is_store=1), fwd_b_sel is 0 whatever its indices match.
- R4: fwd_st_sel is 1 exactly when mem_is_store is set, mem_rs2 is nonzero, wb_we is set and wb_rd equals mem_rs2. No non-store ever gets it.
- R5: Load-use stall (bypassing build). A load in execute with ex_we set and a nonzero ex_rd stalls in two cases: ex_rd equals id_rs1, or ex_rd equals id_rs2 of a non-store. The stall raises hold_pc, hold_ifid and kill_idex in the same cycle.
- R6: A load in execute followed by a store in decode that uses the loaded register only as its data (id_rs2) causes no stall.
- R7: In the bypassing build, a store in decode stalls in the following case. Its nonzero id_rs2 equals mem_rd with mem_we set, and the instruction in execute does not also write that register.
- R8: In the interlock build, all bypass selects are 0. A stall is raised when either nonzero decode source equals ex_rd with ex_we set, or equals mem_rd with mem_we set.
- R9: redirect=1 raises kill_ifid and kill_idex and forces hold_pc and hold_ifid to 0, overriding any stall.
- R10: After reset all counters are 0. At each clock edge out of reset, stall_count adds 1 per stall cycle, flush_count adds 1 per redirect cycle, and fwd_count adds the number of nonzero selects among fwd_a_sel, fwd_b_sel and fwd_st_sel. The counters wrap at their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counters |
| id_rs1 | input | REG_W | First source of the decode instruction |
| id_rs2 | input | REG_W | Second source of the decode instruction |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | REG_W | First source of the execute instruction |
| ex_rs2 | input | REG_W | Second source of the execute instruction |
| ex_rd | input | REG_W | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_store | input | 1 | Execute instruction is a store |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rs2 | input | REG_W | Store-data source of the memory-stage instruction |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | REG_W | Destination of the writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| redirect | input | 1 | Taken branch or jump resolved in execute |
| fwd_a_sel | output | 2 | First execute operand source: 0 regfile, 1 EX/MEM, 2 MEM/WB |
| fwd_b_sel | output | 2 | Second execute operand source, same code |
| fwd_st_sel | output | 1 | Store data from the MEM/WB result |
| hold_pc | output | 1 | Keep the program counter |
| hold_ifid | output | 1 | Keep the fetch/decode register |
| kill_ifid | output | 1 | Load a bubble into the fetch/decode register |
| kill_idex | output | 1 | Load a bubble into the decode/execute register |
| stall_count | output | CNT_W | Stall cycles seen |
| fwd_count | output | CNT_W | Bypass events seen |
| flush_count | output | CNT_W | Redirects seen |

## Verification
All selects, holds and kills are combinational, so they are due in the same cycle as the input pattern. The bench drives each pattern on the falling edge and samples these outputs 2 ns later, well before the next rising edge. Each counter register updates on the following rising edge. The bench therefore reads the counters 1 ns after that edge and compares them with running totals it computes from its own model of the same pattern. Both builds are instanced side by side and swept over every combination of a three-register index set for the bypass fields and for the stall fields.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic             ex_is_store,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_rs2,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output opnd_src_e        sel_a,
  output opnd_src_e        sel_b,
  output logic             sel_st
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  function automatic opnd_src_e pick(input logic [REG_W-1:0] rs,
                                     input logic [REG_W-1:0] m_rd, input logic m_we,
                                     input logic [REG_W-1:0] w_rd, input logic w_we);
    if (rs == ZERO_REG)           pick = SRC_RF;
    else if (m_we && m_rd == rs)  pick = SRC_EXMEM;
    else if (w_we && w_rd == rs)  pick = SRC_MEMWB;
    else                          pick = SRC_RF;
  endfunction

  generate
    if (FORWARD_EN) begin : g_bypass
      assign sel_a  = pick(ex_rs1, mem_rd, mem_we, wb_rd, wb_we);
      assign sel_b  = ex_is_store ? SRC_RF : pick(ex_rs2, mem_rd, mem_we, wb_rd, wb_we);
      assign sel_st = mem_is_store && (mem_rs2 != ZERO_REG) && wb_we && (wb_rd == mem_rs2);
    end else begin : g_none
      assign sel_a  = SRC_RF;
      assign sel_b  = SRC_RF;
      assign sel_st = 1'b0;
    end
  endgenerate

  assert_store_b_rf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_store |-> sel_b == SRC_RF);
  assert_st_only_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_st |-> (mem_is_store && wb_we));
  assert_x0_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == ZERO_REG) |-> sel_a == SRC_RF);
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_W      = 5,
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             redirect,
  output logic             stall,
  output logic             hold_pc,
  output logic             hold_ifid,
  output logic             kill_ifid,
  output logic             kill_idex
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic need;

  generate
    if (FORWARD_EN) begin : g_bypass
      logic load_use, store_gap;
      always_comb begin
        load_use  = ex_is_load && ex_we && (ex_rd != ZERO_REG) &&
                    ((id_rs1 == ex_rd) || (!id_is_store && id_rs2 == ex_rd));
        store_gap = id_is_store && (id_rs2 != ZERO_REG) && mem_we && (mem_rd == id_rs2) &&
                    !(ex_we && ex_rd == id_rs2);
        need      = load_use || store_gap;
      end
    end else begin : g_interlock
      logic hit1, hit2;
      always_comb begin
        hit1 = (id_rs1 != ZERO_REG) &&
               ((ex_we && ex_rd == id_rs1) || (mem_we && mem_rd == id_rs1));
        hit2 = (id_rs2 != ZERO_REG) &&
               ((ex_we && ex_rd == id_rs2) || (mem_we && mem_rd == id_rs2));
        need = hit1 || hit2;
      end
    end
  endgenerate

  always_comb begin
    stall     = need && !redirect;
    hold_pc   = stall;
    hold_ifid = stall;
    kill_ifid = redirect;
    kill_idex = stall || redirect;
  end

  assert_redirect_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!hold_pc && !hold_ifid && kill_ifid && kill_idex));
  assert_stall_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pc |-> (hold_ifid && kill_idex && !kill_ifid));
endmodule

// File: rtl/hz_event_ctr.sv
module hz_event_ctr #(
  parameter int CNT_W = 16,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      past_ok <= 1'b0;
    end else begin
      count   <= count + CNT_W'(inc);
      past_ok <= 1'b1;
    end
  end

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (count - $past(count)) == CNT_W'($past(inc)));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int CNT_W      = 16,
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic             ex_is_store,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_rs2,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  input  logic             redirect,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             fwd_st_sel,
  output logic             hold_pc,
  output logic             hold_ifid,
  output logic             kill_ifid,
  output logic             kill_idex,
  output logic [CNT_W-1:0] stall_count,
  output logic [CNT_W-1:0] fwd_count,
  output logic [CNT_W-1:0] flush_count
);
  localparam int FWD_INC_W = 2;

  opnd_src_e            sel_a, sel_b;
  logic                 sel_st, stall;
  logic [FWD_INC_W-1:0] fwd_events;

  hz_fwd_unit #(.REG_W(REG_W), .FORWARD_EN(FORWARD_EN)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_is_store(ex_is_store),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_rs2(mem_rs2), .mem_is_store(mem_is_store),
    .wb_rd(wb_rd), .wb_we(wb_we),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st)
  );

  hz_stall_unit #(.REG_W(REG_W), .FORWARD_EN(FORWARD_EN)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .redirect(redirect),
    .stall(stall), .hold_pc(hold_pc), .hold_ifid(hold_ifid),
    .kill_ifid(kill_ifid), .kill_idex(kill_idex)
  );

  assign fwd_a_sel  = sel_a;
  assign fwd_b_sel  = sel_b;
  assign fwd_st_sel = sel_st;
  assign fwd_events = FWD_INC_W'(sel_a != SRC_RF) + FWD_INC_W'(sel_b != SRC_RF)
                    + FWD_INC_W'(sel_st);

  hz_event_ctr #(.CNT_W(CNT_W), .INC_W(1)) u_stall_ctr (
    .clk(clk), .rst_n(rst_n), .inc(stall), .count(stall_count));
  hz_event_ctr #(.CNT_W(CNT_W), .INC_W(FWD_INC_W)) u_fwd_ctr (
    .clk(clk), .rst_n(rst_n), .inc(fwd_events), .count(fwd_count));
  hz_event_ctr #(.CNT_W(CNT_W), .INC_W(1)) u_flush_ctr (
    .clk(clk), .rst_n(rst_n), .inc(redirect), .count(flush_count));

  assert_interlock_no_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !FORWARD_EN |-> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0 && !fwd_st_sel));
endmodule

// File: tb/tb_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hazard_ctrl;
  localparam int RW = 5;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_is_store, ex_we, ex_is_load, ex_is_store, mem_we, mem_is_store, wb_we, redirect;

  logic [1:0] fa, fb, ia, ib;
  logic fst, ist, hp, hi, ki, kx, ihp, ihi, iki, ikx;
  logic [CW-1:0] sc, fc, flc, isc, ifc, iflc;

  hazard_ctrl #(.REG_W(RW), .CNT_W(CW), .FORWARD_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .ex_is_store(ex_is_store), .mem_rd(mem_rd), .mem_we(mem_we), .mem_rs2(mem_rs2),
    .mem_is_store(mem_is_store), .wb_rd(wb_rd), .wb_we(wb_we), .redirect(redirect),
    .fwd_a_sel(fa), .fwd_b_sel(fb), .fwd_st_sel(fst), .hold_pc(hp), .hold_ifid(hi),
    .kill_ifid(ki), .kill_idex(kx), .stall_count(sc), .fwd_count(fc), .flush_count(flc));

  hazard_ctrl #(.REG_W(RW), .CNT_W(CW), .FORWARD_EN(1'b0)) dut_il (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .ex_is_store(ex_is_store), .mem_rd(mem_rd), .mem_we(mem_we), .mem_rs2(mem_rs2),
    .mem_is_store(mem_is_store), .wb_rd(wb_rd), .wb_we(wb_we), .redirect(redirect),
    .fwd_a_sel(ia), .fwd_b_sel(ib), .fwd_st_sel(ist), .hold_pc(ihp), .hold_ifid(ihi),
    .kill_ifid(iki), .kill_idex(ikx), .stall_count(isc), .fwd_count(ifc), .flush_count(iflc));

  int n_chk = 0, n_bad = 0;
  int e_sc = 0, e_fc = 0, e_flc = 0, e_isc = 0, e_iflc = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int src(input logic [RW-1:0] rs);
    if (rs == 0) return 0;
    if (mem_we && mem_rd == rs) return 1;
    if (wb_we && wb_rd == rs) return 2;
    return 0;
  endfunction

  task automatic apply();
    int ea, eb, est, estall, eistall;
    bit lu, sg, h1, h2;
    #2;
    // R1/R2 bypass selects; R3 store second operand; R4 store data path
    ea  = src(ex_rs1);
    eb  = ex_is_store ? 0 : src(ex_rs2);
    est = (mem_is_store && mem_rs2 != 0 && wb_we && wb_rd == mem_rs2) ? 1 : 0;
    // R5 load-use, R6 store data exempt, R7 store gap
    lu = ex_is_load && ex_we && ex_rd != 0 &&
         (id_rs1 == ex_rd || (!id_is_store && id_rs2 == ex_rd));
    sg = id_is_store && id_rs2 != 0 && mem_we && mem_rd == id_rs2 && !(ex_we && ex_rd == id_rs2);
    estall = (lu || sg) && !redirect;
    // R8 interlock
    h1 = id_rs1 != 0 && ((ex_we && ex_rd == id_rs1) || (mem_we && mem_rd == id_rs1));
    h2 = id_rs2 != 0 && ((ex_we && ex_rd == id_rs2) || (mem_we && mem_rd == id_rs2));
    eistall = (h1 || h2) && !redirect;

    check("R1/R2", "fwd_a_sel", fa, ea);
    check("R1/R3", "fwd_b_sel", fb, eb);
    check("R4", "fwd_st_sel", fst, est);
    check("R5/R6/R7", "hold_pc", hp, estall);
    check("R5", "hold_ifid", hi, estall);
    check("R9", "kill_ifid", ki, redirect);
    check("R5/R9", "kill_idex", kx, estall | redirect);
    check("R8", "interlock selects", int'(ia) + int'(ib) + int'(ist), 0);
    check("R8/R9", "interlock hold_pc", ihp, eistall);
    check("R8/R9", "interlock kill_idex", ikx, eistall | redirect);

    e_sc  += estall;
    e_fc  += (ea != 0) + (eb != 0) + est;
    e_flc += redirect;
    e_isc += eistall;
    e_iflc += redirect;
    @(posedge clk); #1;
    // R10 counters one edge later
    check("R10", "stall_count", sc, e_sc % 65536);
    check("R10", "fwd_count", fc, e_fc % 65536);
    check("R10", "flush_count", flc, e_flc % 65536);
    check("R10", "interlock stall_count", isc, e_isc % 65536);
    check("R10", "interlock fwd_count", ifc, 0);
    check("R10", "interlock flush_count", iflc, e_iflc % 65536);
    @(negedge clk);
  endtask

  task automatic clear();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
    {id_is_store, ex_we, ex_is_load, ex_is_store, mem_we, mem_is_store, wb_we, redirect} = '0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset stall_count", sc, 0);
    check("R10", "reset fwd_count", fc, 0);
    check("R10", "reset flush_count", flc, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // bypass sweep
    for (int a = 0; a < 3; a++) for (int b = 0; b < 3; b++)
    for (int st = 0; st < 2; st++) for (int m = 0; m < 3; m++)
    for (int mw = 0; mw < 2; mw++) for (int w = 0; w < 3; w++)
    for (int ww = 0; ww < 2; ww++) for (int ms = 0; ms < 2; ms++)
    for (int md = 0; md < 3; md++) begin
      clear();
      ex_rs1 = RW'(a); ex_rs2 = RW'(b); ex_is_store = st[0];
      mem_rd = RW'(m); mem_we = mw[0]; wb_rd = RW'(w); wb_we = ww[0];
      mem_is_store = ms[0]; mem_rs2 = RW'(md);
      apply();
    end

    // stall / flush sweep
    for (int r1 = 0; r1 < 3; r1++) for (int r2 = 0; r2 < 3; r2++)
    for (int is = 0; is < 2; is++) for (int e = 0; e < 3; e++)
    for (int ew = 0; ew < 2; ew++) for (int el = 0; el < 2; el++)
    for (int m = 0; m < 3; m++) for (int mw = 0; mw < 2; mw++)
    for (int rd = 0; rd < 2; rd++) begin
      clear();
      id_rs1 = RW'(r1); id_rs2 = RW'(r2); id_is_store = is[0];
      ex_rd = RW'(e); ex_we = ew[0]; ex_is_load = el[0];
      mem_rd = RW'(m); mem_we = mw[0]; redirect = rd[0];
      apply();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule